// File: doc/BRIEF.md
# Tick compare timer

A bank of free-running 64-bit tick timers, each paired with a compare (limit) register. Bit 63 of every value written to either register is not stored as count or limit data. It sets or clears the channel's disabled flag instead, and reads return that flag in the same bit position. All channels advance together on a shared tick enable, which nominally runs at 100 MHz. A channel that holds an armed compare and is enabled fires once when its count reaches the limit. If the limit written is already at or below the count, the channel fires on the next tick instead.

There are three channels. Channel 0 is the plain tick. Channels 1 and 2 are the system tick and the hypervisor system tick. A firing channel produces a one-cycle set strobe towards the soft-interrupt register, which lives outside this block. Channel 0 drives its own strobe. Channels 1 and 2 share a single strobe. Software reaches both registers of every channel through one write port and one combinational read port.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, every channel reads count and limit as 0x8000_0000_0000_0000 (disabled flag set, all other bits zero), and no strobe is produced until a channel is armed again.
- R2: A count write (wr_lim_i=0) loads bits 62:0 as the count and bit 63 as the disabled flag. A count read (rd_lim_i=0) returns {disabled, count}. A count write takes priority over a tick in the same cycle.
- R3: Each clock edge with tick_en_i high adds one to every channel's 63-bit count, wrapping from all ones to zero. With tick_en_i low the count holds.
- R4: A limit write (wr_lim_i=1) stores bits 62:0 as the compare value and bit 63 as the disabled flag. A limit read returns {disabled, compare}.
- R5: A channel armed by a limit write fires on the first tick edge after which its count is at or above the compare value. If the compare value is already at or below the count, that is the next tick. The strobe is high for exactly the one cycle following that edge.
- R6: A channel fires at most once per limit write. A limit write with compare value zero, or with bit 63 set, leaves the channel unarmed and cancels any earlier arm.
- R7: While the disabled flag is set, the channel never fires. Setting the flag through a count write does not cancel the arm, so clearing it later with another count write lets the pending compare fire.
- R8: Channel 0 drives tick_set_o. Channels 1 and 2 drive stick_set_o. If both fire on the same edge, stick_set_o gives a single one-cycle strobe.
- R9: A write to channel select 3 changes no channel, and a read of channel select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Advance all counts by one on this edge |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 2 | Write channel select (0 tick, 1 system tick, 2 hypervisor system tick) |
| wr_lim_i | input | 1 | Write target: 0 count, 1 limit |
| wr_data_i | input | 64 | Write data; bit 63 is the disable bit |
| rd_ch_i | input | 2 | Read channel select |
| rd_lim_i | input | 1 | Read target: 0 count, 1 limit |
| rd_data_o | output | 64 | Read data, disable flag in bit 63 |
| tick_set_o | output | 1 | One-cycle set strobe for the tick interrupt bit |
| stick_set_o | output | 1 | One-cycle set strobe for the shared system-timer interrupt bit |

## Verification
The channel assertions take for granted that tick_en_i and the write controls are known values from the first edge after reset. They also assume that only one register of a channel is written per cycle, which the single write port enforces. The stimulus changes every input on the falling clock edge and holds it steady across the rising edge. A tick is issued in the same cycle as a write only in the one directed case that checks count-write priority. Every other tick run happens with the write strobe low, so each expected strobe count follows directly from the count and limit values written.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic {
    REG_COUNT = 1'b0,
    REG_LIMIT = 1'b1
  } tmr_reg_e;
endpackage

// File: rtl/tick_channel.sv
module tick_channel
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_i,
  input  tmr_reg_e      wr_reg_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] limit_o,
  output logic          fire_o
);
  localparam int unsigned VW = DW - 1;

  logic [VW-1:0] cnt_q, lim_q;
  logic          dis_q, armed_q, fire_q;
  logic          cnt_we, lim_we, hit, fire_d;
  logic [DW-1:0] cnt_inc;

  assign cnt_we  = wr_i && (wr_reg_i == REG_COUNT);
  assign lim_we  = wr_i && (wr_reg_i == REG_LIMIT);
  // widened so the all-ones count still compares above the limit
  assign cnt_inc = {1'b0, cnt_q} + {{(DW-1){1'b0}}, 1'b1};
  assign hit     = cnt_inc >= {1'b0, lim_q};
  assign fire_d  = tick_i && armed_q && !dis_q && hit && !lim_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      lim_q   <= '0;
      dis_q   <= 1'b1;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= fire_d;
      if (cnt_we) begin
        cnt_q <= wr_data_i[VW-1:0];
        dis_q <= wr_data_i[DW-1];
      end else if (tick_i) begin
        cnt_q <= cnt_inc[VW-1:0];
      end
      if (lim_we) begin
        lim_q   <= wr_data_i[VW-1:0];
        dis_q   <= wr_data_i[DW-1];
        armed_q <= (|wr_data_i[VW-1:0]) && !wr_data_i[DW-1];
      end else if (fire_d) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign count_o = {dis_q, cnt_q};
  assign limit_o = {dis_q, lim_q};
  assign fire_o  = fire_q;

  a_r3_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we) |=> $stable(cnt_q));
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_we) |=> (cnt_q == VW'($past(cnt_q) + 1'b1)));
  a_r5_fire_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_q) |-> $past(tick_i && armed_q));
  a_r6_once_per_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> !armed_q);
  a_r6_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_we && wr_data_i[VW-1:0] == '0) |=> !armed_q);
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_q |=> !fire_q);
endmodule

// File: rtl/tick_rd_mux.sv
module tick_rd_mux #(
  parameter int unsigned DW  = 64,
  parameter int unsigned NCH = 3,
  parameter int unsigned SW  = 2
) (
  input  logic [NCH-1:0][DW-1:0] count_i,
  input  logic [NCH-1:0][DW-1:0] limit_i,
  input  logic [SW-1:0]          sel_i,
  input  logic                   lim_i,
  output logic [DW-1:0]          data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_i == SW'(i)) data_o = lim_i ? limit_i[i] : count_i[i];
    end
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DW  = 64,
  parameter int unsigned NCH = 3,
  parameter int unsigned SW  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_en_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_ch_i,
  input  logic          wr_lim_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [SW-1:0] rd_ch_i,
  input  logic          rd_lim_i,
  output logic [DW-1:0] rd_data_o,
  output logic          tick_set_o,
  output logic          stick_set_o
);
  logic [NCH-1:0][DW-1:0] count_w, limit_w;
  logic [NCH-1:0]         fire_w;
  tmr_reg_e               wr_reg;

  assign wr_reg = wr_lim_i ? REG_LIMIT : REG_COUNT;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tick_channel #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_en_i),
      .wr_i     (wr_en_i && (wr_ch_i == SW'(g))),
      .wr_reg_i (wr_reg),
      .wr_data_i(wr_data_i),
      .count_o  (count_w[g]),
      .limit_o  (limit_w[g]),
      .fire_o   (fire_w[g])
    );
  end

  tick_rd_mux #(.DW(DW), .NCH(NCH), .SW(SW)) u_rd (
    .count_i(count_w),
    .limit_i(limit_w),
    .sel_i  (rd_ch_i),
    .lim_i  (rd_lim_i),
    .data_o (rd_data_o)
  );

  // channel 0: tick bit; all others share the system-timer bit
  assign tick_set_o  = fire_w[0];
  assign stick_set_o = |fire_w[NCH-1:1];

  a_r8_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stick_set_o |=> !stick_set_o);
endmodule

// File: tb/sim_tick_cmp_timer.sv
module sim_tick_cmp_timer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  ch;
    logic        lim;
    logic [63:0] d;
    logic [63:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    '{OP_RD, 2'd0, 1'b0, 64'h0, DIS, 4'd1},                 // R1
    '{OP_RD, 2'd2, 1'b1, 64'h0, DIS, 4'd1},                 // R1
    '{OP_RD, 2'd1, 1'b0, 64'h0, DIS, 4'd1},                 // R1
    '{OP_WR, 2'd0, 1'b0, 64'h10, 64'h0, 4'd2},              // R2
    '{OP_RD, 2'd0, 1'b0, 64'h0, 64'h10, 4'd2},              // R2
    '{OP_WR, 2'd0, 1'b1, 64'h14, 64'h0, 4'd4},              // R4
    '{OP_RD, 2'd0, 1'b1, 64'h0, 64'h14, 4'd4},              // R4
    '{OP_TK, 2'd0, 1'b0, 64'd3, 64'd0, 4'd5},               // R5 cnt 19
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd1, 4'd5},               // R5 reaches 20
    '{OP_TK, 2'd0, 1'b0, 64'd5, 64'd0, 4'd6},               // R6 once per arm
    '{OP_RD, 2'd0, 1'b0, 64'h0, 64'h19, 4'd3},              // R3 cnt 25
    '{OP_WR, 2'd0, 1'b1, 64'h5, 64'h0, 4'd5},               // R5 limit in past
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd1, 4'd5},               // R5
    '{OP_WR, 2'd0, 1'b1, 64'h0, 64'h0, 4'd6},               // R6 zero limit
    '{OP_TK, 2'd0, 1'b0, 64'd4, 64'd0, 4'd6},               // R6 cnt 30
    '{OP_WR, 2'd0, 1'b1, DIS | 64'h28, 64'h0, 4'd4},        // R4 disabled limit
    '{OP_TK, 2'd0, 1'b0, 64'd20, 64'd0, 4'd7},              // R7 cnt 50
    '{OP_RD, 2'd0, 1'b0, 64'h0, DIS | 64'h32, 4'd2},        // R2
    '{OP_RD, 2'd0, 1'b1, 64'h0, DIS | 64'h28, 4'd4},        // R4
    '{OP_WR, 2'd0, 1'b1, 64'h40, 64'h0, 4'd5},              // R5 arm at 64
    '{OP_WR, 2'd0, 1'b0, DIS | 64'h3C, 64'h0, 4'd7},        // R7 disable by count
    '{OP_TK, 2'd0, 1'b0, 64'd10, 64'd0, 4'd7},              // R7
    '{OP_WR, 2'd0, 1'b0, 64'h3C, 64'h0, 4'd7},              // R7 re-enable
    '{OP_TK, 2'd0, 1'b0, 64'd3, 64'd0, 4'd7},               // R7 cnt 63
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd1, 4'd7},               // R7 pending fires
    '{OP_WR, 2'd1, 1'b0, 64'h0, 64'h0, 4'd8},               // R8
    '{OP_WR, 2'd1, 1'b1, 64'h3, 64'h0, 4'd8},               // R8
    '{OP_TK, 2'd1, 1'b0, 64'd3, 64'd1, 4'd8},               // R8 ch1 -> stick
    '{OP_WR, 2'd2, 1'b0, 64'h0, 64'h0, 4'd8},               // R8
    '{OP_WR, 2'd2, 1'b1, 64'h2, 64'h0, 4'd8},               // R8
    '{OP_TK, 2'd2, 1'b0, 64'd2, 64'd1, 4'd8},               // R8 ch2 -> stick
    '{OP_WR, 2'd1, 1'b0, 64'h0, 64'h0, 4'd8},               // R8
    '{OP_WR, 2'd1, 1'b1, 64'h5, 64'h0, 4'd8},               // R8
    '{OP_WR, 2'd2, 1'b0, 64'h0, 64'h0, 4'd8},               // R8
    '{OP_WR, 2'd2, 1'b1, 64'h5, 64'h0, 4'd8},               // R8
    '{OP_TK, 2'd1, 1'b0, 64'd5, 64'd1, 4'd8},               // R8 merged pulse
    '{OP_WR, 2'd0, 1'b0, 64'h7FFF_FFFF_FFFF_FFFD, 64'h0, 4'd3}, // R3
    '{OP_WR, 2'd0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 4'd5}, // R5
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd0, 4'd5},               // R5
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd1, 4'd5},               // R5 at top value
    '{OP_TK, 2'd0, 1'b0, 64'd1, 64'd0, 4'd3},               // R3 wraps
    '{OP_RD, 2'd0, 1'b0, 64'h0, 64'h0, 4'd3},               // R3
    '{OP_WR, 2'd3, 1'b0, 64'h1234, 64'h0, 4'd9},            // R9
    '{OP_RD, 2'd0, 1'b0, 64'h0, 64'h0, 4'd9},               // R9
    '{OP_RD, 2'd3, 1'b0, 64'h0, 64'h0, 4'd9},               // R9
    '{OP_RD, 2'd3, 1'b1, 64'h0, 64'h0, 4'd9},               // R9
    '{OP_RD, 2'd2, 1'b1, 64'h0, 64'h5, 4'd9}                // R9
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_ch_i = '0;
  logic        wr_lim_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_ch_i = '0;
  logic        rd_lim_i = 1'b0;
  logic [63:0] rd_data_o;
  logic        tick_set_o, stick_set_o;

  int checks = 0, errors = 0;
  int n_tick, n_stick;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_cmp_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_en_i(tick_en_i),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_lim_i(wr_lim_i),
    .wr_data_i(wr_data_i), .rd_ch_i(rd_ch_i), .rd_lim_i(rd_lim_i),
    .rd_data_o(rd_data_o), .tick_set_o(tick_set_o), .stick_set_o(stick_set_o)
  );

  task automatic check(input int r, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] ch, input logic lim, input logic [63:0] d);
    wr_en_i = 1'b1; wr_ch_i = ch; wr_lim_i = lim; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] ch, input logic lim, output logic [63:0] v);
    rd_ch_i = ch; rd_lim_i = lim;
    #1 v = rd_data_o;
  endtask

  task automatic run(input int n);
    n_tick = 0; n_stick = 0;
    tick_en_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      n_tick += int'(tick_set_o);
      n_stick += int'(stick_set_o);
    end
    tick_en_i = 1'b0;
    @(posedge clk); @(negedge clk);
    n_tick += int'(tick_set_o);
    n_stick += int'(stick_set_o);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        OP_WR: do_wr(VEC[k].ch, VEC[k].lim, VEC[k].d);
        OP_RD: begin
          do_rd(VEC[k].ch, VEC[k].lim, v);
          check(int'(VEC[k].r), v, VEC[k].e);
        end
        default: begin
          run(int'(VEC[k].d));
          check(int'(VEC[k].r), 64'(VEC[k].ch == 2'd0 ? n_tick : n_stick), VEC[k].e);
        end
      endcase
    end

    // R1: reset while armed, then no strobes and reset values
    do_wr(2'd0, 1'b0, 64'h0);
    do_wr(2'd0, 1'b1, 64'h2);
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      do_rd(2'(c), 1'b0, v); check(1, v, DIS);
      do_rd(2'(c), 1'b1, v); check(1, v, DIS);
    end
    run(5);
    check(1, 64'(n_tick + n_stick), 64'd0);

    // R2: count write wins over a tick in the same cycle
    tick_en_i = 1'b1;
    do_wr(2'd0, 1'b0, 64'h100);
    tick_en_i = 1'b0;
    do_rd(2'd0, 1'b0, v);
    check(2, v, 64'h100);

    // R3: count holds with tick enable low
    repeat (4) @(negedge clk);
    do_rd(2'd0, 1'b0, v);
    check(3, v, 64'h100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule